// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A front end gives it a fetch address. In the same cycle it returns a one-bit direction. It also returns the opinion of each of its two internal components. When the branch later resolves, the back end sends the branch address, the real outcome, and the two component opinions that were reported at lookup time. The block then trains itself on that information.

There are two components. The first is a per-branch table of 2-bit saturating counters, indexed by low address bits. The second is a table of 2-bit counters indexed by address bits joined with a short register of recent branch outcomes. That register is shared by all branches, so the same branch can use a different counter for each recent-outcome pattern. A third table of 2-bit counters, indexed like the per-branch table, learns which component to trust for each branch.

The lookup path is purely combinational, with no valid/ready pair. The update path is a single-cycle strobe, `upd_valid`. It is always accepted and never applies back-pressure, so no ready signal exists. Branch target prediction and history repair after misprediction are not part of this block.

Top module: `tourn_bp`

## Requirements
- R1: After reset, every counter in all three tables reads binary 01 (weakly not-taken / weakly favour the per-branch component). The outcome history reads all zeros. Every lookup therefore returns not-taken on all three prediction outputs.
- R2: A per-branch counter adds one on a taken outcome and subtracts one on a not-taken outcome, and predicts taken when its MSB is 1. Starting from a saturated value, the predicted direction changes only after two consecutive opposite outcomes.
- R3: Counters saturate: a taken outcome at 11 leaves 11, and a not-taken outcome at 00 leaves 00.
- R4: On each accepted update, the real outcome enters bit 0 of `hist_o` (1 = taken) and the older bits move one place toward the MSB.
- R5: The history-correlated counter is selected by {upd/lookup PC bits [ALIGN_W+CORR_PC_W-1:ALIGN_W], history}. The same branch under two different histories therefore uses two different counters.
- R6: The final prediction equals the correlated component's prediction when the selector counter's MSB is 1, and the per-branch prediction otherwise.
- R7: The selector counter changes only when the supplied component opinions differ. It counts up when the correlated opinion matched the outcome, and down when the per-branch opinion matched it.
- R8: Lookup outputs follow `lk_pc` and the current state in the same cycle. State changes only at a clock edge with `upd_valid` high; with `upd_valid` low the update inputs have no effect.
- R9: The per-branch and selector tables are indexed by PC bits [ALIGN_W+LOC_IDX_W-1:ALIGN_W]. Two addresses that differ only above those bits share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Final predicted direction |
| lk_local_taken | output | 1 | Per-branch component opinion |
| lk_corr_taken | output | 1 | History-correlated component opinion |
| upd_valid | input | 1 | Training strobe, one update per cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_local_taken | input | 1 | Per-branch opinion given at lookup |
| upd_corr_taken | input | 1 | Correlated opinion given at lookup |
| hist_o | output | HIST_W | Current outcome history, newest in bit 0 |

## Verification
A mixed address and outcome sequence is compared step by step against a behavioural model. This sequence includes aliasing addresses, so it separates correct index slicing from shifted or truncated slicing.

A strict taken/not-taken alternation on one branch defeats the per-branch counter on every prediction, while the history-correlated counter learns the pattern. A correct selector must therefore end up choosing the correlated side.

Runs of identical outcomes expose counter wrap-around and wrong flip points. Hand-made update pairs with agreeing and disagreeing opinions show whether the selector trains only on disagreement.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_MIN     = 2'b00;
  localparam ctr2_t CTR_WEAK_LO = 2'b01;
  localparam ctr2_t CTR_MAX     = 2'b11;

  // Saturating step toward "up" (1) or "down" (0).
  function automatic ctr2_t ctr_step(ctr2_t c, logic up);
    ctr2_t r;
    if (up) r = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
    else    r = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_dir(ctr2_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int    IDX_W   = 6,
  parameter ctr2_t RST_VAL = CTR_WEAK_LO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];

  assign rd_val = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
    end
  end

  AST_TBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> mem[$past(wr_idx)] == $past(mem[wr_idx])); // R8

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && mem[wr_idx] == CTR_MAX) |=> mem[$past(wr_idx)] == CTR_MAX); // R3

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && mem[wr_idx] == CTR_MIN) |=> mem[$past(wr_idx)] == CTR_MIN); // R3
endmodule

// File: rtl/tbp_hist.sv
module tbp_hist #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[W-2:0], bit_in};
  end

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist)); // R8

  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist[0] == $past(bit_in)); // R4
endmodule

// File: rtl/tourn_bp.sv
module tourn_bp
  import tbp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ALIGN_W   = 2,
  parameter int LOC_IDX_W = 6,
  parameter int CORR_PC_W = 4,
  parameter int HIST_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic              lk_local_taken,
  output logic              lk_corr_taken,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic              upd_local_taken,
  input  logic              upd_corr_taken,
  output logic [HIST_W-1:0] hist_o
);
  localparam int CORR_IDX_W = CORR_PC_W + HIST_W;

  logic [HIST_W-1:0]     hist;
  logic [LOC_IDX_W-1:0]  lk_loc_idx, up_loc_idx;
  logic [CORR_IDX_W-1:0] lk_cor_idx, up_cor_idx;
  ctr2_t                 loc_val, cor_val, cho_val;
  logic                  cho_wr;

  assign lk_loc_idx = lk_pc[ALIGN_W +: LOC_IDX_W];
  assign up_loc_idx = upd_pc[ALIGN_W +: LOC_IDX_W];
  assign lk_cor_idx = {lk_pc[ALIGN_W +: CORR_PC_W], hist};
  assign up_cor_idx = {upd_pc[ALIGN_W +: CORR_PC_W], hist};
  assign cho_wr     = upd_valid && (upd_local_taken != upd_corr_taken);

  tbp_ctr_table #(.IDX_W(LOC_IDX_W), .RST_VAL(CTR_WEAK_LO)) u_local (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_loc_idx), .rd_val(loc_val),
    .wr_en(upd_valid), .wr_idx(up_loc_idx), .wr_up(upd_taken));

  tbp_ctr_table #(.IDX_W(CORR_IDX_W), .RST_VAL(CTR_WEAK_LO)) u_corr (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_cor_idx), .rd_val(cor_val),
    .wr_en(upd_valid), .wr_idx(up_cor_idx), .wr_up(upd_taken));

  tbp_ctr_table #(.IDX_W(LOC_IDX_W), .RST_VAL(CTR_WEAK_LO)) u_choose (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_loc_idx), .rd_val(cho_val),
    .wr_en(cho_wr), .wr_idx(up_loc_idx), .wr_up(upd_corr_taken == upd_taken));

  tbp_hist #(.W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(upd_valid), .bit_in(upd_taken), .hist(hist));

  assign lk_local_taken = ctr_dir(loc_val);
  assign lk_corr_taken  = ctr_dir(cor_val);
  assign lk_taken       = ctr_dir(cho_val) ? lk_corr_taken : lk_local_taken;
  assign hist_o         = hist;

  AST_HIST_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> hist_o[HIST_W-1:1] == $past(hist_o[HIST_W-2:0])); // R4
endmodule

// File: tb/tb_tourn_bp.sv
module tb_tourn_bp;
  localparam int PC_W = 32, ALIGN_W = 2, LOC_IDX_W = 6, CORR_PC_W = 4, HIST_W = 4;
  localparam int LD = 1 << LOC_IDX_W;
  localparam int CD = 1 << (CORR_PC_W + HIST_W);

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic lk_taken, lk_local_taken, lk_corr_taken;
  logic upd_valid = 0, upd_taken = 0, upd_local_taken = 0, upd_corr_taken = 0;
  logic [HIST_W-1:0] hist_o;

  always #4 clk = ~clk;

  tourn_bp #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .LOC_IDX_W(LOC_IDX_W),
             .CORR_PC_W(CORR_PC_W), .HIST_W(HIST_W)) dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_local_taken(lk_local_taken), .lk_corr_taken(lk_corr_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_local_taken(upd_local_taken), .upd_corr_taken(upd_corr_taken), .hist_o(hist_o));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Behavioural model written from the requirements
  logic [1:0] m_loc [LD];
  logic [1:0] m_cor [CD];
  logic [1:0] m_cho [LD];
  logic [HIST_W-1:0] m_hist;

  function automatic logic [1:0] sat(logic [1:0] c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
  function automatic int li(logic [PC_W-1:0] pc);
    return int'(pc[ALIGN_W +: LOC_IDX_W]);
  endfunction
  function automatic int ci(logic [PC_W-1:0] pc);
    return int'({pc[ALIGN_W +: CORR_PC_W], m_hist});
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; upd_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < LD; i++) begin m_loc[i] = 2'b01; m_cho[i] = 2'b01; end
    for (int i = 0; i < CD; i++) m_cor[i] = 2'b01;
    m_hist = '0;
  endtask

  // Lookup, compare all outputs to the model
  task automatic look_model(logic [PC_W-1:0] pc, string tag);
    logic el, ec, ef;
    lk_pc = pc; #1;
    el = m_loc[li(pc)][1];
    ec = m_cor[ci(pc)][1];
    ef = m_cho[li(pc)][1] ? ec : el;
    chk(lk_local_taken == el, {tag, " local R2"}, lk_local_taken, el);
    chk(lk_corr_taken == ec, {tag, " corr R5"}, lk_corr_taken, ec);
    chk(lk_taken == ef, {tag, " final R6"}, lk_taken, ef);
    chk(hist_o == m_hist, {tag, " hist R4"}, hist_o, m_hist);
  endtask

  // One update (called just after a negedge); returns after the next negedge
  task automatic upd(logic [PC_W-1:0] pc, logic t, logic cl, logic cc);
    upd_valid = 1; upd_pc = pc; upd_taken = t; upd_local_taken = cl; upd_corr_taken = cc;
    @(posedge clk);
    m_loc[li(pc)] = sat(m_loc[li(pc)], t);
    m_cor[ci(pc)] = sat(m_cor[ci(pc)], t);
    if (cl != cc) m_cho[li(pc)] = sat(m_cho[li(pc)], cc == t);
    m_hist = {m_hist[HIST_W-2:0], t};
    @(negedge clk);
    upd_valid = 0;
  endtask

  // Update using the model's own component opinions
  task automatic upd_auto(logic [PC_W-1:0] pc, logic t);
    upd(pc, t, m_loc[li(pc)][1], m_cor[ci(pc)][1]);
  endtask

  localparam int NV = 24;
  localparam logic [32:0] VEC [NV] = '{
    {32'h0000_0100, 1'b1}, {32'h0000_0104, 1'b0}, {32'h0000_0100, 1'b1}, {32'h0000_1100, 1'b1},
    {32'h0000_0108, 1'b1}, {32'h0000_0100, 1'b0}, {32'h0000_0104, 1'b0}, {32'h0000_0100, 1'b1},
    {32'h0000_0200, 1'b1}, {32'h0000_0200, 1'b0}, {32'h0000_0200, 1'b1}, {32'h0000_0200, 1'b0},
    {32'h0000_1100, 1'b0}, {32'h0000_0100, 1'b1}, {32'h0000_013C, 1'b1}, {32'h0000_013C, 1'b1},
    {32'h0000_0108, 1'b0}, {32'h0000_0108, 1'b0}, {32'h0000_0200, 1'b1}, {32'h0000_0200, 1'b0},
    {32'h0000_0104, 1'b1}, {32'h0000_0100, 1'b1}, {32'h0000_1100, 1'b0}, {32'h0000_0200, 1'b1}};

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    lk_pc = 32'h0000_0300; #1;
    chk(lk_taken == 0 && lk_local_taken == 0 && lk_corr_taken == 0, "R1 reset preds", lk_taken, 0);
    chk(hist_o == 0, "R1 reset hist", hist_o, 0);
    @(negedge clk);

    // Vector walk against the model (R2 R5 R6 R9 mixed)
    for (int v = 0; v < NV; v++) begin
      look_model(VEC[v][32:1], $sformatf("vec%0d", v));
      upd_auto(VEC[v][32:1], VEC[v][0]);
    end

    // R8: update strobe low has no effect
    do_reset();
    upd_valid = 0; upd_pc = 32'h0000_0400; upd_taken = 1; upd_local_taken = 0; upd_corr_taken = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    lk_pc = 32'h0000_0400; #1;
    chk(hist_o == 0, "R8 idle hist", hist_o, 0);
    chk(lk_local_taken == 0 && lk_taken == 0, "R8 idle counters", lk_local_taken, 0);

    // R2: flip points from weak and strong states
    @(negedge clk);
    upd(32'h0000_0400, 1, 0, 0); lk_pc = 32'h0000_0400; #1;
    chk(lk_local_taken == 1, "R2 weak flip", lk_local_taken, 1);
    @(negedge clk);
    upd(32'h0000_0400, 1, 1, 0);
    upd(32'h0000_0400, 0, 1, 0); #1;
    chk(lk_local_taken == 1, "R2 strong first miss", lk_local_taken, 1);
    @(negedge clk);
    upd(32'h0000_0400, 0, 1, 0); #1;
    chk(lk_local_taken == 0, "R2 strong second miss", lk_local_taken, 0);

    // R3: saturation both ends
    @(negedge clk);
    for (int k = 0; k < 6; k++) upd(32'h0000_0500, 1, 0, 0);
    upd(32'h0000_0500, 0, 0, 0); lk_pc = 32'h0000_0500; #1;
    chk(lk_local_taken == 1, "R3 high saturation", lk_local_taken, 1);
    @(negedge clk);
    for (int k = 0; k < 6; k++) upd(32'h0000_0600, 0, 0, 0);
    upd(32'h0000_0600, 1, 0, 0); lk_pc = 32'h0000_0600; #1;
    chk(lk_local_taken == 0, "R3 low saturation", lk_local_taken, 0);

    // R4: history shift order
    do_reset();
    upd(32'h0000_0700, 1, 0, 0);
    upd(32'h0000_0700, 0, 0, 0);
    upd(32'h0000_0700, 1, 0, 0); #1;
    chk(hist_o == 4'b0101, "R4 history order", hist_o, 5);

    // R5: same branch, different histories, different counters
    do_reset();
    upd(32'h0000_0800, 1, 0, 0);
    lk_pc = 32'h0000_0800; #1;
    chk(lk_corr_taken == 0, "R5 other history", lk_corr_taken, 0);
    @(negedge clk);
    for (int k = 0; k < 4; k++) upd(32'h0000_0844, 0, 0, 0);
    lk_pc = 32'h0000_0800; #1;
    chk(hist_o == 0 && lk_corr_taken == 1, "R5 same history", lk_corr_taken, 1);

    // R9: aliasing addresses share the per-branch entry
    lk_pc = 32'h0000_1800; #1;
    chk(lk_local_taken == 1, "R9 alias shares entry", lk_local_taken, 1);

    // R6: alternating pattern is learned through the selector
    do_reset();
    for (int k = 0; k < 16; k++) upd_auto(32'h0000_0900, (k % 2) == 0);
    lk_pc = 32'h0000_0900; #1;
    chk(lk_taken == 1, "R6 selector picks correlated", lk_taken, 1);
    chk(lk_local_taken == 0, "R6 local wrong on pattern", lk_local_taken, 0);

    // R7: selector trains only on disagreement
    do_reset();
    upd(32'h0000_0A00, 1, 0, 1);
    lk_pc = 32'h0000_0A00; #1;
    chk(lk_local_taken == 1 && lk_corr_taken == 0 && lk_taken == 0,
        "R7 disagreement moves selector", lk_taken, 0);
    do_reset();
    upd(32'h0000_0A00, 1, 0, 0);
    lk_pc = 32'h0000_0A00; #1;
    chk(lk_local_taken == 1 && lk_corr_taken == 0 && lk_taken == 1,
        "R7 agreement leaves selector", lk_taken, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule